// File: doc/BRIEF.md
# Bus Write-Counter Probe

This peripheral measures how many bus writes land on a chosen target address. It serves two access windows, a memory window and an I/O window, on one byte-addressed request port. A window-select input tells which window the request belongs to. Software picks a test by writing a test kind to byte 0 of either window. That write also clears the test's write count. From then on, each write that hits the test's target offset is counted. A data-matching test counts a write only when its access size and data value match the expected ones as well.

Software reads the active test's header back one byte per read. The header gives the test index, the access width, the target offset, the expected data byte, the running count and a zero-terminated name string. Because the header carries all of this, software needs no built-in knowledge of the addresses. On every counted write, a notifying test raises a one-cycle pulse and sets a sticky flag. A read of the active header clears that flag.

Top module: `wr_probe`

## Requirements
- R1: After reset no test is active, and `notify` and `notify_flag` are 0.
- R2: A write to address 0 of either window first stops any active test and clears `notify_flag`. If the full written value is below 3, it then activates test index = window×3 + value (memory window = 0, I/O window = 1), with a count of 0. Any other value leaves no test active.
- R3: While no test is active, every read returns 0 and writes to nonzero addresses change nothing.
- R4: The target offset of test i is the window size of its own window plus i. The window sizes are 2048 for memory (tests 0–2) and 128 for I/O (tests 3–5). Kind 0 (quiet) and kind 1 (any-data) tests add 1 to the count for each write whose address equals the target offset. Data value, access size and the window the write arrived on are not considered.
- R5: A kind 2 (data-match) test counts a target-offset write only if its size is 1 byte and its full data value equals 0xFA.
- R6: The active header holds the following bytes, with unlisted bytes in 0–15 reading 0:

  | Byte(s) | Content |
  |---|---|
  | 0 | Test index |
  | 1 | Access width, 1 |
  | 4–7 | Target offset, little-endian |
  | 8 | Expected data byte: 0xFA for data-match tests, 0xCE otherwise |
  | 12–15 | Count, little-endian |
- R7: From byte 16 the header holds the test name, then one zero byte. The names are "mem-none", "mem-any", "mem-match", "io-none", "io-any" and "io-match", in index order. A read with address + size ≥ 17 + name length returns 0.
- R8: `notify` is high for exactly the cycle after each counted write of a kind 1 or kind 2 test. It is never raised by a kind 0 test.
- R9: `notify_flag` rises together with `notify` and stays high until a read of the active header that passes the length check of R7. A read that fails the check leaves the flag unchanged.
- R10: An access at an address at or above twice its window's size is ignored. A write there has no effect, even at address 256 of the I/O window, and a read there returns 0.
- R11: The read data appears with `rd_valid` in the cycle after `bus_rd`. When `bus_wr` and `bus_rd` are both high, only the write is performed and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_win | input | 1 | Window: 0 memory, 1 I/O |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access size in bytes |
| rd_data | output | 8 | Header byte returned by a read |
| rd_valid | output | 1 | Read response strobe |
| notify | output | 1 | One-cycle pulse per counted notifying write |
| notify_flag | output | 1 | Sticky notify indication |

## Verification
A wrong active test or index shows up right away. The header bytes read back expose it in the cycle after the read, and `notify` exposes it in the cycle after the next target write. A corrupted count or match rule does not show up by itself. It appears only when software reads bytes 12–15, so the bench reads the count after each group of qualifying and near-miss writes. Errors in the sticky flag are checked on both sides of the length boundary, because an off-by-one there either clears the flag or leaves it set one read too late.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int NUM_KIND  = 3;
  localparam int NUM_WIN   = 2;
  localparam int NUM_TEST  = NUM_KIND * NUM_WIN;
  localparam int IDX_W     = $clog2(NUM_TEST);
  localparam int HDR_FIXED = 16;

  typedef enum logic [1:0] {K_QUIET = 2'd0, K_ANY = 2'd1, K_MATCH = 2'd2} kind_e;

  typedef struct packed {
    logic             active;
    logic [IDX_W-1:0] idx;
  } sel_t;

  function automatic kind_e kind_of(input logic [IDX_W-1:0] idx);
    int k;
    k = int'(idx) % NUM_KIND;
    return kind_e'(k[1:0]);
  endfunction

  function automatic logic win_of(input logic [IDX_W-1:0] idx);
    return int'(idx) >= NUM_KIND;
  endfunction

  function automatic int pre_len(input logic [IDX_W-1:0] idx);
    return win_of(idx) ? 3 : 4;
  endfunction

  function automatic int suf_len(input logic [IDX_W-1:0] idx);
    case (kind_of(idx))
      K_QUIET: return 4;
      K_ANY:   return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int hdr_len(input logic [IDX_W-1:0] idx);
    return HDR_FIXED + pre_len(idx) + suf_len(idx) + 1;
  endfunction

  // Character at position pos of the test name; zero past its end.
  function automatic logic [7:0] name_byte(input logic [IDX_W-1:0] idx, input int pos);
    logic [31:0] pre;
    logic [39:0] suf;
    int          pl;
    int          sl;
    pre = win_of(idx) ? {8'h00, "io-"} : "mem-";
    pl  = pre_len(idx);
    sl  = suf_len(idx);
    case (kind_of(idx))
      K_QUIET: suf = {8'h00, "none"};
      K_ANY:   suf = {16'h0000, "any"};
      default: suf = "match";
    endcase
    if (pos < 0)          return 8'h00;
    else if (pos < pl)    return pre[8*(pl-1-pos) +: 8];
    else if (pos < pl+sl) return suf[8*(sl-1-(pos-pl)) +: 8];
    else                  return 8'h00;
  endfunction
endpackage

// File: rtl/wrp_decode.sv
module wrp_decode #(
  parameter int ADDR_W  = 12,
  parameter int MEM_WIN = 2048,
  parameter int IO_WIN  = 128
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_ok,
  output logic              sel_hit,
  output logic              rd_req,
  output logic              rd_in
);
  localparam int MEM_SPAN = 2 * MEM_WIN;
  localparam int IO_SPAN  = 2 * IO_WIN;

  logic in_range;

  always_comb begin
    if (bus_win) in_range = 32'(bus_addr) < 32'(IO_SPAN);
    else         in_range = 32'(bus_addr) < 32'(MEM_SPAN);
    wr_ok   = bus_wr && in_range;
    sel_hit = wr_ok && (bus_addr == '0);
    rd_req  = bus_rd && !bus_wr;
    rd_in   = rd_req && in_range;
  end
endmodule

// File: rtl/wrp_select.sv
module wrp_select
  import wrp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_hit,
  input  logic              bus_win,
  input  logic [DATA_W-1:0] bus_wdata,
  output sel_t              sel_o
);
  sel_t sel_q;
  logic valid_kind;

  assign valid_kind = bus_wdata < DATA_W'(NUM_KIND);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (sel_hit) begin
      if (valid_kind) begin
        sel_q.active <= 1'b1;
        sel_q.idx    <= bus_win ? IDX_W'(NUM_KIND) + IDX_W'(bus_wdata[1:0])
                                : IDX_W'(bus_wdata[1:0]);
      end else begin
        sel_q <= '0;
      end
    end
  end

  assign sel_o = sel_q;

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !sel_q.active);
  p_bad_stop_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_hit && !valid_kind) |=> !sel_q.active);
  p_good_start_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_hit && valid_kind) |=> (sel_q.active && win_of(sel_q.idx) == $past(bus_win)));
endmodule

// File: rtl/wrp_counter.sv
module wrp_counter
  import wrp_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 32,
  parameter int          MEM_WIN    = 2048,
  parameter int          IO_WIN     = 128,
  parameter int          ACC_BYTES  = 1,
  parameter logic [7:0]  MATCH_BYTE = 8'hFA
) (
  input  logic              clk,
  input  logic              rst,
  input  sel_t              sel,
  input  logic              sel_hit,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [2:0]        bus_size,
  input  logic              rd_clear,
  output logic [31:0]       tgt_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              notify_o,
  output logic              flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             notify_q;
  logic             flag_q;
  kind_e            kind;
  logic             addr_hit;
  logic             data_ok;
  logic             counted;

  always_comb begin
    kind     = kind_of(sel.idx);
    tgt_o    = 32'(win_of(sel.idx) ? IO_WIN : MEM_WIN) + 32'(sel.idx);
    addr_hit = 32'(bus_addr) == tgt_o;
    data_ok  = (kind != K_MATCH) ||
               ((32'(bus_size) == 32'(ACC_BYTES)) && (bus_wdata == DATA_W'(MATCH_BYTE)));
    counted  = wr_ok && !sel_hit && sel.active && addr_hit && data_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      notify_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      notify_q <= counted && (kind != K_QUIET);
      if (sel_hit) begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (counted) cnt_q <= cnt_q + CNT_W'(1);
        if (counted && (kind != K_QUIET)) flag_q <= 1'b1;
        else if (rd_clear)                flag_q <= 1'b0;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign notify_o = notify_q;
  assign flag_o   = flag_q;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!notify_q && !flag_q));
  p_sel_clear_r2: assert property (@(posedge clk) disable iff (rst)
    sel_hit |=> (cnt_q == '0 && !flag_q));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel.active && !sel_hit) |=> $stable(cnt_q));
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    !sel_hit |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_match_data_r5: assert property (@(posedge clk) disable iff (rst)
    (!sel_hit && kind == K_MATCH && bus_wdata != DATA_W'(MATCH_BYTE)) |=> $stable(cnt_q));
  p_quiet_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (sel.active && kind == K_QUIET) |=> !notify_q);
  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (rst)
    notify_q |-> flag_q);
endmodule

// File: rtl/wrp_reader.sv
module wrp_reader
  import wrp_pkg::*;
#(
  parameter int         ADDR_W     = 12,
  parameter int         CNT_W      = 32,
  parameter int         ACC_BYTES  = 1,
  parameter logic [7:0] MATCH_BYTE = 8'hFA,
  parameter logic [7:0] IDLE_BYTE  = 8'hCE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              rd_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  sel_t              sel,
  input  logic [31:0]       tgt,
  input  logic [CNT_W-1:0]  cnt,
  output logic              hdr_hit,
  output logic [7:0]        rdata_o,
  output logic              rd_valid_o
);
  logic [31:0] a;
  logic [31:0] cnt32;
  logic [7:0]  hbyte;
  logic [7:0]  rdata_q;
  logic        rd_valid_q;

  always_comb begin
    a       = 32'(bus_addr);
    cnt32   = 32'(cnt);
    hdr_hit = rd_in && sel.active && ((a + 32'(bus_size)) < 32'(hdr_len(sel.idx)));
    case (a)
      32'd0:   hbyte = 8'(sel.idx);
      32'd1:   hbyte = 8'(ACC_BYTES);
      32'd4:   hbyte = tgt[7:0];
      32'd5:   hbyte = tgt[15:8];
      32'd6:   hbyte = tgt[23:16];
      32'd7:   hbyte = tgt[31:24];
      32'd8:   hbyte = (kind_of(sel.idx) == K_MATCH) ? MATCH_BYTE : IDLE_BYTE;
      32'd12:  hbyte = cnt32[7:0];
      32'd13:  hbyte = cnt32[15:8];
      32'd14:  hbyte = cnt32[23:16];
      32'd15:  hbyte = cnt32[31:24];
      32'd2, 32'd3, 32'd9, 32'd10, 32'd11: hbyte = 8'h00;
      default: hbyte = name_byte(sel.idx, int'(a) - HDR_FIXED);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= 8'h00;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) rdata_q <= hdr_hit ? hbyte : 8'h00;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rd_valid_q;

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !sel.active) |=> (rd_valid_q && rdata_q == 8'h00));
  p_past_end_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !hdr_hit) |=> (rdata_q == 8'h00));
  p_rsp_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid_q);
endmodule

// File: rtl/wr_probe.sv
module wr_probe
  import wrp_pkg::*;
#(
  parameter int         ADDR_W     = 12,
  parameter int         DATA_W     = 32,
  parameter int         CNT_W      = 32,
  parameter int         MEM_WIN    = 2048,
  parameter int         IO_WIN     = 128,
  parameter int         ACC_BYTES  = 1,
  parameter logic [7:0] MATCH_BYTE = 8'hFA,
  parameter logic [7:0] IDLE_BYTE  = 8'hCE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [2:0]        bus_size,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              notify,
  output logic              notify_flag
);
  logic             wr_ok;
  logic             sel_hit;
  logic             rd_req;
  logic             rd_in;
  logic             hdr_hit;
  sel_t             sel;
  logic [31:0]      tgt;
  logic [CNT_W-1:0] cnt;

  wrp_decode #(.ADDR_W(ADDR_W), .MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN)) u_decode (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_win(bus_win), .bus_addr(bus_addr),
    .wr_ok(wr_ok), .sel_hit(sel_hit), .rd_req(rd_req), .rd_in(rd_in));

  wrp_select #(.DATA_W(DATA_W)) u_select (
    .clk(clk), .rst(rst), .sel_hit(sel_hit), .bus_win(bus_win),
    .bus_wdata(bus_wdata), .sel_o(sel));

  wrp_counter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MEM_WIN(MEM_WIN),
                .IO_WIN(IO_WIN), .ACC_BYTES(ACC_BYTES), .MATCH_BYTE(MATCH_BYTE)) u_counter (
    .clk(clk), .rst(rst), .sel(sel), .sel_hit(sel_hit), .wr_ok(wr_ok),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .rd_clear(hdr_hit), .tgt_o(tgt), .cnt_o(cnt), .notify_o(notify), .flag_o(notify_flag));

  wrp_reader #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ACC_BYTES(ACC_BYTES),
               .MATCH_BYTE(MATCH_BYTE), .IDLE_BYTE(IDLE_BYTE)) u_reader (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_in(rd_in), .bus_addr(bus_addr),
    .bus_size(bus_size), .sel(sel), .tgt(tgt), .cnt(cnt), .hdr_hit(hdr_hit),
    .rdata_o(rd_data), .rd_valid_o(rd_valid));
endmodule

// File: tb/wr_probe_tb_top.sv
`timescale 1ns/1ps
module wr_probe_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_win = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  bus_size = 3'd1;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        notify;
  logic        notify_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wr_probe dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .rd_data(rd_data), .rd_valid(rd_valid), .notify(notify), .notify_flag(notify_flag));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One write; returns notify as seen in the following cycle.
  task automatic do_wr(input bit win, input int addr, input int data, input int size,
                       output bit ntf);
    @(negedge clk);
    bus_wr = 1'b1; bus_win = win; bus_addr = 12'(addr);
    bus_wdata = 32'(data); bus_size = 3'(size);
    @(negedge clk);
    bus_wr = 1'b0;
    ntf = notify;
  endtask

  task automatic do_rd(input bit win, input int addr, input int size, output logic [7:0] b);
    @(negedge clk);
    bus_rd = 1'b1; bus_win = win; bus_addr = 12'(addr); bus_size = 3'(size);
    @(negedge clk);
    bus_rd = 1'b0;
    check(rd_valid == 1'b1, "R11 rd_valid", rd_valid, 1);
    b = rd_data;
  endtask

  task automatic rd32(input int base, output int v);
    logic [7:0] b;
    v = 0;
    for (int k = 0; k < 4; k++) begin
      do_rd(1'b0, base + k, 1, b);
      v = v | (int'(b) << (8 * k));
    end
  endtask

  task automatic sel(input bit win, input int val);
    bit n;
    do_wr(win, 0, val, 1, n);
  endtask

  function automatic string exp_name(input int idx);
    string p;
    string s;
    p = (idx >= 3) ? "io-" : "mem-";
    case (idx % 3)
      0: s = "none";
      1: s = "any";
      default: s = "match";
    endcase
    return {p, s};
  endfunction

  task automatic t_reset();
    logic [7:0] b;
    bit n;
    check(notify == 1'b0, "R1 notify after reset", notify, 0);
    check(notify_flag == 1'b0, "R1 flag after reset", notify_flag, 0);
    do_rd(1'b0, 0, 1, b);
    check(b == 8'h00, "R1 no test active", b, 0);
    do_wr(1'b0, 2049, 32'h12, 1, n);
    check(n == 1'b0, "R3 idle write no notify", n, 0);
    do_rd(1'b0, 12, 1, b);
    check(b == 8'h00, "R3 idle read zero", b, 0);
  endtask

  task automatic t_any();
    logic [7:0] b;
    int v;
    bit n;
    string nm;
    sel(1'b0, 1);
    do_rd(1'b0, 0, 1, b); check(b == 8'd1, "R6 index byte", b, 1);
    do_rd(1'b0, 1, 1, b); check(b == 8'd1, "R6 width byte", b, 1);
    do_rd(1'b0, 3, 1, b); check(b == 8'd0, "R6 pad byte", b, 0);
    rd32(4, v); check(v == 2049, "R6 R4 target offset", v, 2049);
    do_rd(1'b0, 8, 1, b); check(b == 8'hCE, "R6 data byte any", b, 8'hCE);
    rd32(12, v); check(v == 0, "R2 count starts zero", v, 0);
    do_wr(1'b0, 2049, 32'h12, 4, n); check(n == 1'b1, "R8 pulse on count", n, 1);
    check(notify_flag == 1'b1, "R9 flag set", notify_flag, 1);
    @(negedge clk);
    check(notify == 1'b0, "R8 pulse one cycle", notify, 0);
    do_wr(1'b0, 2049, 32'h0, 2, n);
    do_wr(1'b1, 2049, 32'h0, 1, n);
    check(n == 1'b0, "R10 out-of-range write", n, 0);
    do_wr(1'b1, 256, 32'h0, 1, n);
    do_wr(1'b0, 2050, 32'h33, 1, n); check(n == 1'b0, "R4 miss address", n, 0);
    do_wr(1'b0, 2049, 32'h77, 1, n);
    nm = exp_name(1);
    do_rd(1'b0, 23, 1, b); check(b == 8'h00, "R7 terminator past length", b, 0);
    check(notify_flag == 1'b1, "R9 flag kept on past-end read", notify_flag, 1);
    do_rd(1'b1, 300, 1, b); check(b == 8'h00, "R10 out-of-range read", b, 0);
    for (int k = 0; k < nm.len(); k++) begin
      do_rd(1'b0, 16 + k, 1, b);
      check(b == nm[k], "R7 name byte", b, nm[k]);
    end
    check(notify_flag == 1'b0, "R9 flag cleared by read", notify_flag, 0);
    do_rd(1'b0, 22, 2, b); check(b == 8'h00, "R7 addr+size at length", b, 0);
    rd32(12, v); check(v == 3, "R4 R10 count any", v, 3);
  endtask

  task automatic t_match();
    logic [7:0] b;
    int v;
    bit n;
    sel(1'b0, 2);
    do_rd(1'b0, 8, 1, b); check(b == 8'hFA, "R6 data byte match", b, 8'hFA);
    do_wr(1'b0, 2050, 32'hFA, 1, n); check(n == 1'b1, "R5 match counted", n, 1);
    do_wr(1'b0, 2050, 32'hFA, 2, n); check(n == 1'b0, "R5 size mismatch", n, 0);
    do_wr(1'b0, 2050, 32'hFB, 1, n); check(n == 1'b0, "R5 data mismatch", n, 0);
    do_wr(1'b0, 2050, 32'h1FA, 1, n); check(n == 1'b0, "R5 upper bits mismatch", n, 0);
    do_wr(1'b0, 2049, 32'hFA, 1, n);
    rd32(12, v); check(v == 1, "R5 match count", v, 1);
  endtask

  task automatic t_quiet_io();
    logic [7:0] b;
    int v;
    bit n;
    do_wr(1'b0, 2050, 32'hFA, 1, n);
    check(notify_flag == 1'b1, "R9 flag before select", notify_flag, 1);
    sel(1'b1, 0);
    check(notify_flag == 1'b0, "R2 select clears flag", notify_flag, 0);
    do_rd(1'b1, 0, 1, b); check(b == 8'd3, "R2 io index", b, 3);
    rd32(4, v); check(v == 131, "R4 io target", v, 131);
    do_wr(1'b1, 131, 32'h55, 2, n); check(n == 1'b0, "R8 quiet no pulse", n, 0);
    do_wr(1'b0, 131, 32'h66, 1, n);
    check(notify_flag == 1'b0, "R8 quiet flag low", notify_flag, 0);
    rd32(12, v); check(v == 2, "R4 quiet count any window", v, 2);
    sel(1'b1, 0);
    rd32(12, v); check(v == 0, "R2 reselect clears count", v, 0);
  endtask

  task automatic t_prio();
    int v;
    bit n;
    sel(1'b0, 1);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_win = 1'b0; bus_addr = 12'd2049;
    bus_wdata = 32'h1; bus_size = 3'd1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check(rd_valid == 1'b0, "R11 write wins", rd_valid, 0);
    rd32(12, v); check(v == 1, "R11 write performed", v, 1);
    do_wr(1'b0, 2049, 32'h0, 1, n);
  endtask

  task automatic t_bad_sel();
    logic [7:0] b;
    bit n;
    sel(1'b0, 3);
    do_rd(1'b0, 0, 1, b); check(b == 8'h00, "R2 value 3 stops", b, 0);
    sel(1'b0, 32'h100);
    do_rd(1'b0, 4, 1, b); check(b == 8'h00, "R2 value 0x100 stops", b, 0);
    do_wr(1'b0, 2049, 32'h0, 1, n); check(n == 1'b0, "R3 no count when idle", n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_any();
    t_match();
    t_quiet_io();
    t_prio();
    t_bad_sel();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule